// File: doc/BRIEF.md
# Serial-Loaded Digital Potentiometer Controller

This block is the digital half of a programmable resistor divider. A host writes a wiper position over a three-wire serial link made of a serial clock, an active-low select and a data line. While select is low, each rising serial-clock edge shifts one bit into a serial register, most significant bit first. When select returns high, the register contents move into the wiper latch, and the latch drives the code that the resistor ladder decodes. The serial pins are asynchronous to the block. They pass through a two-flop synchronizer into the system clock domain, and their edges are detected there.

A parameter selects one of two variants. The wide variant has an 8-bit register and latch with codes 0 to 255. The narrow variant has 6 bits and codes 0 to 32; a larger shifted value is clamped to 32 as it is latched. After reset, both the latch and the serial register hold midscale. A separate active-low shutdown input drives two switch enables straight away, without waiting for a clock. One enable opens the top terminal and the other shorts the wiper to the bottom terminal. Shutdown leaves the latched code alone, so the old wiper position returns when shutdown is released.

Top module: `digipot_ctrl`

## Requirements
- R1: After reset, the wiper code is midscale: 128 in the wide variant and 16 in the narrow variant.
- R2: While select is low, each rising serial-clock edge shifts the data bit into the serial register, MSB first. A load takes the last N bits shifted in, where N is 8 (wide) or 6 (narrow). This holds across frames of any length, so bits from an earlier frame fill in when fewer than N bits are sent.
- R3: Serial-clock edges seen while select is high do not change the serial register. This shows at the output: a later select pulse with no clocks reloads the same code.
- R4: The wiper code changes only when select rises, and every rising edge of select causes exactly one load.
- R5: While shutdown is low, both the top-terminal-open output and the wiper-to-bottom short output are 1, with no clock needed. While shutdown is high, both are 0.
- R6: Shutdown does not change the wiper code. A select rise during shutdown still loads the latch, and after release the output shows the latched code.
- R7: In the narrow variant, a shifted 6-bit value above 32 is latched as 32. Values from 0 to 32 are latched unchanged.
- R8: A serial-clock rise that reaches the block in the same synchronized cycle as a select rise is not shifted in.
- R9: The serial register also resets to midscale. A select pulse with no clocks right after reset keeps the code at midscale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sel_n_i | input | 1 | Active-low serial select; its rising edge loads the latch |
| sdat_i | input | 1 | Serial data, MSB first |
| shdn_n_i | input | 1 | Active-low shutdown override |
| wiper_code_o | output | 8 or 6 | Latched wiper code |
| a_open_o | output | 1 | Open the top terminal switch |
| wb_short_o | output | 1 | Short the wiper to the bottom terminal |

## Verification
Two pairs of functions can land in the same cycle. A serial-clock rise can meet a select rise, and a latch load can happen during shutdown. The bench drives the serial clock and select high in the same system cycle, so both cross the synchronizer together; it then checks that the loaded code leaves out that final bit. Separately, it sends a complete frame while shutdown is held low. It checks that the switch enables stay on, that the code still updates, and that the new code is present after release.

// File: rtl/digipot_pkg.sv
package digipot_pkg;

  localparam int SYNC_N   = 3;
  localparam int IDX_SCLK = 0;
  localparam int IDX_SEL  = 1;
  localparam int IDX_DAT  = 2;

  function automatic int code_w(bit wide);
    return wide ? 8 : 6;
  endfunction

  function automatic int code_max(bit wide);
    return wide ? 255 : 32;
  endfunction

  function automatic int code_mid(bit wide);
    return wide ? 128 : 16;
  endfunction

endpackage

// File: rtl/dp_rst_sync.sv
module dp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);

  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/dp_sync_edge.sv
module dp_sync_edge #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);

  // Stages 0..STAGES-1 form the synchronizer; stage STAGES keeps the previous level.
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] q_d;
    logic [STAGES:0] q_r;

    always_comb begin
      q_d = {q_r[STAGES-1:0], async_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= {(STAGES+1){RST_VAL[g]}};
      else        q_r <= q_d;
    end

    assign lvl_o[g]  = q_r[STAGES-1];
    assign rise_o[g] = q_r[STAGES-1] & ~q_r[STAGES];
  end

endmodule

// File: rtl/dp_shift_reg.sv
module dp_shift_reg #(
  parameter int         W      = 8,
  parameter logic [W-1:0] PRESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en_i,
  input  logic         dat_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  always_comb begin
    q_d = q_r;
    if (shift_en_i) q_d = {q_r[W-2:0], dat_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= PRESET;
    else        q_r <= q_d;
  end

  assign q_o = q_r;

endmodule

// File: rtl/dp_wiper_latch.sv
module dp_wiper_latch #(
  parameter int           W      = 8,
  parameter int           MAXV   = 255,
  parameter logic [W-1:0] PRESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam logic [W-1:0] LIMIT = W'(MAXV);

  logic [W-1:0] d_lim;
  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  if (MAXV < (2**W) - 1) begin : g_clamp
    always_comb begin
      d_lim = (d_i > LIMIT) ? LIMIT : d_i;
    end
  end else begin : g_pass
    always_comb begin
      d_lim = d_i;
    end
  end

  always_comb begin
    q_d = q_r;
    if (load_en_i) q_d = d_lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= PRESET;
    else        q_r <= q_d;
  end

  assign q_o = q_r;

endmodule

// File: rtl/digipot_ctrl.sv
module digipot_ctrl
  import digipot_pkg::*;
#(
  parameter bit WIDE        = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk_i,
  input  logic                       sel_n_i,
  input  logic                       sdat_i,
  input  logic                       shdn_n_i,
  output logic [code_w(WIDE)-1:0]    wiper_code_o,
  output logic                       a_open_o,
  output logic                       wb_short_o
);

  localparam int                CODE_W = code_w(WIDE);
  localparam int                MAXV   = code_max(WIDE);
  localparam logic [CODE_W-1:0] MID    = CODE_W'(code_mid(WIDE));
  localparam logic [SYNC_N-1:0] SYNC_RST = SYNC_N'(1) << IDX_SEL;

  logic              rst_q_n;
  logic [SYNC_N-1:0] pin_raw;
  logic [SYNC_N-1:0] pin_lvl;
  logic [SYNC_N-1:0] pin_rise;
  logic              sel_lvl;
  logic              shift_stb;
  logic              load_stb;
  logic [CODE_W-1:0] ser_q;
  logic              unused_pins;

  dp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (rst_q_n)
  );

  always_comb begin
    pin_raw           = '0;
    pin_raw[IDX_SCLK] = sclk_i;
    pin_raw[IDX_SEL]  = sel_n_i;
    pin_raw[IDX_DAT]  = sdat_i;
  end

  dp_sync_edge #(
    .N       (SYNC_N),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .async_i (pin_raw),
    .lvl_o   (pin_lvl),
    .rise_o  (pin_rise)
  );

  assign unused_pins = ^{pin_lvl[IDX_SCLK], pin_rise[IDX_DAT]};

  // Select high (deselected) masks any serial clock rise seen in the same cycle.
  assign sel_lvl   = pin_lvl[IDX_SEL];
  assign shift_stb = pin_rise[IDX_SCLK] & ~sel_lvl;
  assign load_stb  = pin_rise[IDX_SEL];

  dp_shift_reg #(
    .W      (CODE_W),
    .PRESET (MID)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .shift_en_i (shift_stb),
    .dat_i      (pin_lvl[IDX_DAT]),
    .q_o        (ser_q)
  );

  dp_wiper_latch #(
    .W      (CODE_W),
    .MAXV   (MAXV),
    .PRESET (MID)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load_en_i (load_stb),
    .d_i       (ser_q),
    .q_o       (wiper_code_o)
  );

  // Shutdown acts on the switches directly, without a clock.
  assign a_open_o   = ~shdn_n_i;
  assign wb_short_o = ~shdn_n_i;

endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter bit WIDE   = 1'b1,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shdn_n_i,
  input logic [CODE_W-1:0] wiper_code_o,
  input logic              a_open_o,
  input logic              wb_short_o,
  input logic              shift_stb,
  input logic              load_stb,
  input logic              sel_lvl
);

  AST_SHDN_SWITCHES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_i |-> (a_open_o && wb_short_o)); // R5

  AST_SHDN_SWITCHES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_n_i |-> (!a_open_o && !wb_short_o)); // R5

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=> $stable(wiper_code_o)); // R4

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb); // R4

  AST_NO_SHIFT_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> !sel_lvl); // R3

  AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |=> !shift_stb); // R2

  if (!WIDE) begin : g_narrow
    AST_CODE_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wiper_code_o) <= 32); // R7
  end

endmodule

bind digipot_ctrl dp_checker #(
  .WIDE   (WIDE),
  .CODE_W (CODE_W)
) u_dp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .shdn_n_i     (shdn_n_i),
  .wiper_code_o (wiper_code_o),
  .a_open_o     (a_open_o),
  .wb_short_o   (wb_short_o),
  .shift_stb    (shift_stb),
  .load_stb     (load_stb),
  .sel_lvl      (sel_lvl)
);

// File: tb/test_digipot_ctrl.sv
module test_digipot_ctrl;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sel_n = 1'b1;
  logic       sdat = 1'b0;
  logic       shdn_n = 1'b1;
  logic [7:0] code_w;
  logic [5:0] code_n;
  logic       aopen_w, wbsh_w, aopen_n, wbsh_n;

  int errors = 0;
  int checks = 0;
  logic [7:0] sr_w;
  logic [5:0] sr_n;
  int exp_w, exp_n;

  always #2 clk = ~clk;

  digipot_ctrl #(.WIDE(1'b1)) i_digipot_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .sdat_i(sdat),
    .shdn_n_i(shdn_n), .wiper_code_o(code_w), .a_open_o(aopen_w), .wb_short_o(wbsh_w)
  );

  digipot_ctrl #(.WIDE(1'b0)) i_digipot_ctrl_narrow (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .sdat_i(sdat),
    .shdn_n_i(shdn_n), .wiper_code_o(code_n), .a_open_o(aopen_n), .wb_short_o(wbsh_n)
  );

  function automatic int clamp_n(logic [5:0] v);
    return (int'(v) > 32) ? 32 : int'(v);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_codes(string req);
    chk(req, int'(code_w), exp_w);
    chk(req, int'(code_n), exp_n);
  endtask

  task automatic send_bits(logic [15:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      wait_cyc(HALF);
      sclk = 1'b1;
      sr_w = {sr_w[6:0], bits[i]};
      sr_n = {sr_n[4:0], bits[i]};
      wait_cyc(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(logic [15:0] bits, int n, string req);
    sel_n = 1'b0;
    wait_cyc(HALF);
    send_bits(bits, n);
    wait_cyc(HALF);
    check_codes("R4 before select rise");
    sel_n = 1'b1;
    exp_w = int'(sr_w);
    exp_n = clamp_n(sr_n);
    wait_cyc(8);
    check_codes(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5A));
    sr_w = 8'd128;
    sr_n = 6'd16;
    exp_w = 128;
    exp_n = 16;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);
    check_codes("R1 reset midscale");
    chk("R1 switches off", int'({aopen_w, wbsh_w, aopen_n, wbsh_n}), 0);

    // R9: select pulse with no clocks after reset keeps midscale
    sel_n = 1'b0;
    wait_cyc(HALF);
    sel_n = 1'b1;
    wait_cyc(8);
    check_codes("R9 preset serial register");

    frame(16'h00A5, 8, "R2 pattern A5");
    frame(16'h0000, 8, "R2 zero");
    frame(16'h00FF, 8, "R2 all ones / R7 clamp 63");
    frame(16'h0021, 8, "R7 clamp 33");
    frame(16'h0020, 8, "R7 exact 32");
    frame(16'h001F, 8, "R7 value 31");
    frame(16'h0005, 3, "R2 short frame keeps old bits");
    frame(16'h0ABC, 12, "R2 long frame last bits");

    // R3: clocks while deselected do not touch the serial register
    for (int i = 0; i < 10; i++) begin
      sdat = 1'($urandom);
      wait_cyc(HALF);
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
    end
    sel_n = 1'b0;
    wait_cyc(HALF);
    sel_n = 1'b1;
    wait_cyc(8);
    check_codes("R3 clocks while deselected ignored");

    // R8: serial clock rise coincident with select rise is not shifted
    sel_n = 1'b0;
    wait_cyc(HALF);
    send_bits(16'h0009, 4);
    sdat = ~sr_w[0];
    wait_cyc(HALF);
    sclk = 1'b1;
    sel_n = 1'b1;
    exp_w = int'(sr_w);
    exp_n = clamp_n(sr_n);
    wait_cyc(8);
    sclk = 1'b0;
    check_codes("R8 coincident edge not shifted");

    // R5/R6: shutdown
    shdn_n = 1'b0;
    #1;
    chk("R5 a_open async", int'({aopen_w, aopen_n}), 3);
    chk("R5 wb_short async", int'({wbsh_w, wbsh_n}), 3);
    wait_cyc(4);
    check_codes("R6 code unchanged by shutdown");
    frame(16'h003C, 8, "R6 load during shutdown");
    chk("R5 switches held during load", int'({aopen_w, wbsh_w, aopen_n, wbsh_n}), 15);
    shdn_n = 1'b1;
    #1;
    chk("R5 switches released", int'({aopen_w, wbsh_w, aopen_n, wbsh_n}), 0);
    wait_cyc(2);
    check_codes("R6 position after release");

    // Random frames
    for (int k = 0; k < 40; k++) begin
      int len;
      len = 1 + int'($urandom % 12);
      frame(16'($urandom), len, "R2 random frame / R7");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule